// File: doc/BRIEF.md
# Interrupt Stack Frame Push Sequencer

This block produces, one after another, the memory writes that build the stack frame a processor lays down when it enters an interrupt or exception handler. A start strobe captures the whole frame context: the starting stack pointer, the old stack and code selectors, the old stack pointer and instruction pointer, the flags word, the four data segment selectors, an optional error code, and six mode flags. The flags are gate width (32 or 16 bit), stack width (32 or 16 bit), entry to an inner privilege level, entry from virtual-8086 mode, 64-bit mode, and error code present.

From the mode flags the block works out which items belong in the frame and how large each slot is. It issues one write at a time on a valid/ready handshake, giving the address, the data truncated to the slot size, and a size code. When the last write has been accepted, it pulses done and shows the final stack pointer, ready to be loaded into the stack pointer register. Every address is computed from the captured start pointer and the index of the write. No running pointer is carried from one write to the next.

Top module: `isf_push_seq`

## Requirements
- R1: After reset `busy`, `wr_valid` and `done` are 0 and `new_sp` is 0.
- R2: On a 32-bit gate with an inner privilege change (not 64-bit mode), the items go out in this order: old SS, old ESP, EFLAGS, old CS, old EIP. They go at start pointer minus 4, 8, 12, 16 and 20, each with size code 1 (4 bytes), and selectors are zero-extended to 32 bits.
- R3: On a 16-bit gate the same items are written with size code 0 (2 bytes) at minus 2, 4, 6, 8 and 10, each data value truncated to its low 16 bits.
- R4: When an error code is present it is the last write, one slot below the previous one (4 bytes lower for a 32-bit gate, 2 bytes for a 16-bit gate, 8 bytes in 64-bit mode).
- R5: On an inner-privilege entry from virtual-8086 mode (not 64-bit mode), GS, FS, DS and ES are written first, in that order, in slots of the gate's size, and the rest of the frame follows below them.
- R6: On a same-privilege entry (not 64-bit mode) only EFLAGS, old CS and old EIP are written, then the optional error code; the virtual-8086 flag has no effect on the writes.
- R7: With a 16-bit stack, addresses are the low 16 bits of the offset, zero-extended, and the final pointer keeps the start pointer's upper bits and replaces only its low 16 bits. With a 32-bit stack the same rule applies to the low 32 bits.
- R8: In 64-bit mode the start pointer is first rounded down to a multiple of 16. All five items (SS, RSP, RFLAGS, CS, RIP) are always written with size code 2 (8 bytes) at minus 8 to minus 40 from the rounded pointer, and the error code comes 8 below that. The stack width and virtual-8086 flags are ignored.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_size` hold steady; no new write starts before the current one is accepted.
- R10: `done` is high for exactly one cycle, the cycle after the last write is accepted. `new_sp` then equals the start pointer minus the total frame size, under the R7/R8 rules, and keeps that value until the next frame finishes.
- R11: A start strobe while `busy` is high is ignored: the frame in progress completes unchanged from the context captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame; context is captured in this cycle when idle |
| in_gate32 | input | 1 | 1 = 32-bit gate, 0 = 16-bit gate |
| in_stack32 | input | 1 | 1 = 32-bit stack, 0 = 16-bit stack |
| in_inner | input | 1 | Entry changes to an inner privilege level |
| in_v86 | input | 1 | Entry comes from virtual-8086 mode |
| in_long64 | input | 1 | 64-bit mode entry |
| in_has_err | input | 1 | Error code is pushed |
| start_sp | input | PTR_W | Stack pointer the frame is built below |
| old_ss | input | SEL_W | Old stack selector |
| old_esp | input | PTR_W | Old stack pointer |
| old_flags | input | FLAG_W | Flags word |
| old_cs | input | SEL_W | Old code selector |
| old_eip | input | PTR_W | Return instruction pointer |
| sel_gs | input | SEL_W | GS selector |
| sel_fs | input | SEL_W | FS selector |
| sel_ds | input | SEL_W | DS selector |
| sel_es | input | SEL_W | ES selector |
| err_code | input | ERR_W | Error code |
| wr_valid | output | 1 | A write is offered |
| wr_ready | input | 1 | The write is accepted in this cycle |
| wr_addr | output | PTR_W | Stack offset of the write |
| wr_data | output | 64 | Write data, zero above the slot size |
| wr_size | output | 2 | 0 = 2 bytes, 1 = 4 bytes, 2 = 8 bytes |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the last accepted write |
| new_sp | output | PTR_W | Final stack pointer of the last frame |

## Verification
Two events can arrive in the same cycle: a stalled write that must stay put, and a fresh start strobe that must be ignored. The bench sweeps every combination of the six mode flags over three start pointers, chosen so that the 16-bit, 32-bit and 64-bit address spaces each wrap. The ready line follows a pseudo-random pattern, so writes stall at irregular points. In a subset of frames a start with different context and flags is strobed in the first issuing cycles, often on top of a stall. Each write, the cycle in which done appears and the final pointer are compared with a frame model computed arithmetically in the bench. A stalled write must also present the same address and data in the next cycle.

// File: rtl/isf_pkg.sv
// Shared types for the interrupt stack frame push sequencer.
// Assumes: item order in isf_kind_e is the push order of a frame.
package isf_pkg;

    localparam int NUM_KINDS = 10;

    // Frame items in the order they leave for the stack
    typedef enum logic [3:0] {
        KIND_GS  = 4'd0,
        KIND_FS  = 4'd1,
        KIND_DS  = 4'd2,
        KIND_ES  = 4'd3,
        KIND_SS  = 4'd4,
        KIND_SP  = 4'd5,
        KIND_FL  = 4'd6,
        KIND_CS  = 4'd7,
        KIND_IP  = 4'd8,
        KIND_ERR = 4'd9
    } isf_kind_e;

    // Slot size codes seen on wr_size
    typedef enum logic [1:0] {
        SZ_WORD  = 2'd0,
        SZ_DWORD = 2'd1,
        SZ_QWORD = 2'd2
    } isf_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FIN   = 2'd2
    } isf_state_e;

    typedef struct packed {
        logic gate32;
        logic stack32;
        logic inner;
        logic v86;
        logic long64;
        logic has_err;
    } isf_mode_t;

endpackage

// File: rtl/isf_frame_plan.sv
// Frame planner: from the captured mode flags, decides which items the
// frame contains, the slot size, the pointer width mask and the count.
// Assumes: PTR_W >= 32; purely combinational.
module isf_frame_plan
    import isf_pkg::*;
#(
    parameter int PTR_W = 64,
    parameter int CNT_W = 4
) (
    input  isf_mode_t              mode,
    output logic [NUM_KINDS-1:0]   kind_en,
    output isf_size_e              size,
    output logic [1:0]             shift,
    output logic [PTR_W-1:0]       ptr_mask,
    output logic [CNT_W-1:0]       n_writes
);

    logic seg_push;
    logic stack_push;

    // Which items are part of this frame
    always_comb begin
        seg_push   = mode.inner && mode.v86 && !mode.long64;
        stack_push = mode.inner || mode.long64;
        kind_en = '0;
        kind_en[KIND_GS]  = seg_push;
        kind_en[KIND_FS]  = seg_push;
        kind_en[KIND_DS]  = seg_push;
        kind_en[KIND_ES]  = seg_push;
        kind_en[KIND_SS]  = stack_push;
        kind_en[KIND_SP]  = stack_push;
        kind_en[KIND_FL]  = 1'b1;
        kind_en[KIND_CS]  = 1'b1;
        kind_en[KIND_IP]  = 1'b1;
        kind_en[KIND_ERR] = mode.has_err;
    end

    // Total number of writes in the frame
    always_comb begin
        n_writes = CNT_W'($countones(kind_en));
    end

    // Slot size and its log2 in bytes
    always_comb begin
        if (mode.long64) begin
            size  = SZ_QWORD;
            shift = 2'd3;
        end else if (mode.gate32) begin
            size  = SZ_DWORD;
            shift = 2'd2;
        end else begin
            size  = SZ_WORD;
            shift = 2'd1;
        end
    end

    // Address space in which the stack pointer wraps
    always_comb begin
        if (mode.long64) begin
            ptr_mask = '1;
        end else if (mode.stack32) begin
            ptr_mask = PTR_W'(32'hFFFF_FFFF);
        end else begin
            ptr_mask = PTR_W'(16'hFFFF);
        end
    end

endmodule

// File: rtl/isf_kind_select.sv
// Item selector: maps the write index to the frame item of that rank
// among the enabled items, using a prefix count per item.
// Assumes: widx is below the number of enabled items while issuing.
module isf_kind_select
    import isf_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [NUM_KINDS-1:0] kind_en,
    input  logic [CNT_W-1:0]     widx,
    output isf_kind_e            kind,
    output logic                 hit_any
);

    logic [NUM_KINDS-1:0] hit;
    logic [CNT_W-1:0]     rank [NUM_KINDS];

    // Rank of every item among the enabled items below it
    for (genvar i = 0; i < NUM_KINDS; i++) begin : g_rank
        if (i == 0) begin : g_first
            assign rank[i] = '0;
        end else begin : g_rest
            assign rank[i] = CNT_W'($countones(kind_en[i-1:0]));
        end
        assign hit[i] = kind_en[i] && (rank[i] == widx);
    end

    // Encode the single matching item
    always_comb begin
        kind = KIND_GS;
        for (int i = 0; i < NUM_KINDS; i++) begin
            if (hit[i]) begin
                kind = isf_kind_e'(4'(i));
            end
        end
        hit_any = |hit;
    end

endmodule

// File: rtl/isf_slot_gen.sv
// Slot generator: forms the address and data of the current write and
// the final stack pointer, all from the captured start pointer.
// Assumes: PTR_W <= 64; shift is 1, 2 or 3.
module isf_slot_gen
    import isf_pkg::*;
#(
    parameter int PTR_W  = 64,
    parameter int SEL_W  = 16,
    parameter int FLAG_W = 32,
    parameter int ERR_W  = 16,
    parameter int CNT_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic [PTR_W-1:0]  start_sp,
    input  logic [PTR_W-1:0]  ptr_mask,
    input  logic [1:0]        shift,
    input  logic              long64,
    input  logic [CNT_W-1:0]  widx,
    input  logic [CNT_W-1:0]  n_writes,
    input  isf_kind_e         kind,
    input  isf_size_e         size,
    input  logic [SEL_W-1:0]  v_ss,
    input  logic [PTR_W-1:0]  v_sp,
    input  logic [FLAG_W-1:0] v_flags,
    input  logic [SEL_W-1:0]  v_cs,
    input  logic [PTR_W-1:0]  v_ip,
    input  logic [SEL_W-1:0]  v_gs,
    input  logic [SEL_W-1:0]  v_fs,
    input  logic [SEL_W-1:0]  v_ds,
    input  logic [SEL_W-1:0]  v_es,
    input  logic [ERR_W-1:0]  v_err,
    output logic [PTR_W-1:0]  addr,
    output logic [DATA_W-1:0] data,
    output logic [PTR_W-1:0]  end_sp
);

    logic [PTR_W-1:0]  base;
    logic [PTR_W-1:0]  offset;
    logic [PTR_W-1:0]  total;
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] size_mask;

    // Base pointer, rounded to 16 bytes in 64-bit mode
    always_comb begin
        base = long64 ? {start_sp[PTR_W-1:4], 4'b0000} : start_sp;
    end

    // Address of slot widx and the pointer after the whole frame
    always_comb begin
        offset = (PTR_W'(widx) + PTR_W'(1)) << shift;
        total  = PTR_W'(n_writes) << shift;
        addr   = (base - offset) & ptr_mask;
        end_sp = (start_sp & ~ptr_mask) | ((base - total) & ptr_mask);
    end

    // Value of the current item, zero-extended
    always_comb begin
        case (kind)
            KIND_GS:  raw = DATA_W'(v_gs);
            KIND_FS:  raw = DATA_W'(v_fs);
            KIND_DS:  raw = DATA_W'(v_ds);
            KIND_ES:  raw = DATA_W'(v_es);
            KIND_SS:  raw = DATA_W'(v_ss);
            KIND_SP:  raw = DATA_W'(v_sp);
            KIND_FL:  raw = DATA_W'(v_flags);
            KIND_CS:  raw = DATA_W'(v_cs);
            KIND_IP:  raw = DATA_W'(v_ip);
            KIND_ERR: raw = DATA_W'(v_err);
            default:  raw = '0;
        endcase
    end

    // Truncate the value to the slot size
    always_comb begin
        case (size)
            SZ_WORD:  size_mask = DATA_W'(16'hFFFF);
            SZ_DWORD: size_mask = DATA_W'(32'hFFFF_FFFF);
            default:  size_mask = '1;
        endcase
        data = raw & size_mask;
    end

endmodule

// File: rtl/isf_push_seq.sv
// Interrupt stack frame push sequencer (top). Captures the frame context
// on start, offers one stack write at a time on a valid/ready handshake
// and pulses done with the final stack pointer after the last write.
// Assumes: synchronous active-low reset; start is ignored while busy.
module isf_push_seq
    import isf_pkg::*;
#(
    parameter int PTR_W  = 64,
    parameter int SEL_W  = 16,
    parameter int FLAG_W = 32,
    parameter int ERR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_gate32,
    input  logic              in_stack32,
    input  logic              in_inner,
    input  logic              in_v86,
    input  logic              in_long64,
    input  logic              in_has_err,
    input  logic [PTR_W-1:0]  start_sp,
    input  logic [SEL_W-1:0]  old_ss,
    input  logic [PTR_W-1:0]  old_esp,
    input  logic [FLAG_W-1:0] old_flags,
    input  logic [SEL_W-1:0]  old_cs,
    input  logic [PTR_W-1:0]  old_eip,
    input  logic [SEL_W-1:0]  sel_gs,
    input  logic [SEL_W-1:0]  sel_fs,
    input  logic [SEL_W-1:0]  sel_ds,
    input  logic [SEL_W-1:0]  sel_es,
    input  logic [ERR_W-1:0]  err_code,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [63:0]       wr_data,
    output logic [1:0]        wr_size,
    output logic              busy,
    output logic              done,
    output logic [PTR_W-1:0]  new_sp
);

    localparam int DATA_W = 64;
    localparam int CNT_W  = $clog2(NUM_KINDS + 1);

    isf_state_e        st_q;
    logic [CNT_W-1:0]  widx_q;
    isf_mode_t         mode_q;
    logic [PTR_W-1:0]  sp0_q;
    logic [PTR_W-1:0]  fin_sp_q;
    logic [SEL_W-1:0]  ss_q, cs_q, gs_q, fs_q, ds_q, es_q;
    logic [PTR_W-1:0]  esp_q, eip_q;
    logic [FLAG_W-1:0] flags_q;
    logic [ERR_W-1:0]  err_q;

    logic [NUM_KINDS-1:0] kind_en;
    isf_size_e            size;
    logic [1:0]           shift;
    logic [PTR_W-1:0]     ptr_mask;
    logic [CNT_W-1:0]     n_writes;
    isf_kind_e            kind;
    logic                 hit_any;
    logic [PTR_W-1:0]     end_sp;
    logic                 last;

    isf_frame_plan #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_plan (
        .mode     (mode_q),
        .kind_en  (kind_en),
        .size     (size),
        .shift    (shift),
        .ptr_mask (ptr_mask),
        .n_writes (n_writes)
    );

    isf_kind_select #(.CNT_W(CNT_W)) u_sel (
        .kind_en (kind_en),
        .widx    (widx_q),
        .kind    (kind),
        .hit_any (hit_any)
    );

    isf_slot_gen #(
        .PTR_W(PTR_W), .SEL_W(SEL_W), .FLAG_W(FLAG_W),
        .ERR_W(ERR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
    ) u_slot (
        .start_sp (sp0_q),
        .ptr_mask (ptr_mask),
        .shift    (shift),
        .long64   (mode_q.long64),
        .widx     (widx_q),
        .n_writes (n_writes),
        .kind     (kind),
        .size     (size),
        .v_ss     (ss_q),
        .v_sp     (esp_q),
        .v_flags  (flags_q),
        .v_cs     (cs_q),
        .v_ip     (eip_q),
        .v_gs     (gs_q),
        .v_fs     (fs_q),
        .v_ds     (ds_q),
        .v_es     (es_q),
        .v_err    (err_q),
        .addr     (wr_addr),
        .data     (wr_data),
        .end_sp   (end_sp)
    );

    // Last write of the frame is the one at the top index
    always_comb begin
        last = (widx_q == n_writes - CNT_W'(1));
    end

    // Sequencer state, write index and final pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            widx_q   <= '0;
            fin_sp_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q   <= ST_ISSUE;
                        widx_q <= '0;
                    end
                end
                ST_ISSUE: begin
                    if (wr_ready) begin
                        if (last) begin
                            st_q     <= ST_FIN;
                            fin_sp_q <= end_sp;
                        end else begin
                            widx_q <= widx_q + CNT_W'(1);
                        end
                    end
                end
                ST_FIN: begin
                    st_q <= ST_IDLE;
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Context capture, only when a frame is accepted in idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            sp0_q   <= '0;
            ss_q    <= '0;
            esp_q   <= '0;
            flags_q <= '0;
            cs_q    <= '0;
            eip_q   <= '0;
            gs_q    <= '0;
            fs_q    <= '0;
            ds_q    <= '0;
            es_q    <= '0;
            err_q   <= '0;
        end else if (st_q == ST_IDLE && start) begin
            mode_q  <= '{gate32: in_gate32, stack32: in_stack32, inner: in_inner,
                         v86: in_v86, long64: in_long64, has_err: in_has_err};
            sp0_q   <= start_sp;
            ss_q    <= old_ss;
            esp_q   <= old_esp;
            flags_q <= old_flags;
            cs_q    <= old_cs;
            eip_q   <= old_eip;
            gs_q    <= sel_gs;
            fs_q    <= sel_fs;
            ds_q    <= sel_ds;
            es_q    <= sel_es;
            err_q   <= err_code;
        end
    end

    // Port view of the state
    always_comb begin
        wr_valid = (st_q == ST_ISSUE);
        wr_size  = size;
        busy     = (st_q != ST_IDLE);
        done     = (st_q == ST_FIN);
        new_sp   = fin_sp_q;
    end

    // R9: a stalled write holds still
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_size));

    // R10: done only right after an accepted write
    p_done_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_valid && wr_ready));

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: the final pointer only moves when done shows
    p_sp_moves_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(new_sp) |-> done);

    // R8: eight-byte slots sit on eight-byte boundaries
    p_qword_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && (wr_size == SZ_QWORD) |-> (wr_addr[2:0] == 3'b000));

    // R2: every offered write maps to a frame item
    p_item_found_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> hit_any);

    // R11: a start during a frame does not cut it short
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && start |=> wr_valid || done);

endmodule

// File: tb/tb_isf_push_seq.sv
module tb_isf_push_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_gate32 = 1'b0, in_stack32 = 1'b0, in_inner = 1'b0;
    logic        in_v86 = 1'b0, in_long64 = 1'b0, in_has_err = 1'b0;
    logic [63:0] start_sp = '0;
    logic [15:0] old_ss = 16'hA51C, old_cs = 16'h3B2F;
    logic [63:0] old_esp = 64'hDEAD_BEEF_1357_9BDF;
    logic [63:0] old_eip = 64'h0123_4567_89AB_CDEF;
    logic [31:0] old_flags = 32'h0024_0A93;
    logic [15:0] sel_gs = 16'h1A11, sel_fs = 16'h2B22, sel_ds = 16'h3C33, sel_es = 16'h4D44;
    logic [15:0] err_code = 16'hE00D;
    logic        wr_valid, wr_ready = 1'b0;
    logic [63:0] wr_addr, wr_data, new_sp;
    logic [1:0]  wr_size;
    logic        busy, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] lf = 8'hA5;

    logic [63:0] exp_addr [10];
    logic [63:0] exp_data [10];
    logic [1:0]  exp_size [10];
    int          exp_kind [10];
    int          exp_n;
    logic [63:0] exp_sp;

    isf_push_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_gate32(in_gate32), .in_stack32(in_stack32), .in_inner(in_inner),
        .in_v86(in_v86), .in_long64(in_long64), .in_has_err(in_has_err),
        .start_sp(start_sp), .old_ss(old_ss), .old_esp(old_esp),
        .old_flags(old_flags), .old_cs(old_cs), .old_eip(old_eip),
        .sel_gs(sel_gs), .sel_fs(sel_fs), .sel_ds(sel_ds), .sel_es(sel_es),
        .err_code(err_code), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size),
        .busy(busy), .done(done), .new_sp(new_sp)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [63:0] item_value(int k);
        case (k)
            0: return 64'(sel_gs);
            1: return 64'(sel_fs);
            2: return 64'(sel_ds);
            3: return 64'(sel_es);
            4: return 64'(old_ss);
            5: return old_esp;
            6: return 64'(old_flags);
            7: return 64'(old_cs);
            8: return old_eip;
            default: return 64'(err_code);
        endcase
    endfunction

    // Frame model straight from the requirements
    task automatic build_expected(input bit g32, input bit s32, input bit inn,
                                  input bit v86, input bit lng, input bit herr,
                                  input logic [63:0] sp);
        logic [63:0] sz, base, mask, dmask;
        bit en;
        exp_n = 0;
        sz    = lng ? 64'd8 : (g32 ? 64'd4 : 64'd2);
        base  = lng ? (sp & ~64'hF) : sp;
        mask  = lng ? '1 : (s32 ? 64'hFFFF_FFFF : 64'hFFFF);
        dmask = lng ? '1 : (g32 ? 64'hFFFF_FFFF : 64'hFFFF);
        for (int k = 0; k < 10; k++) begin
            if (k < 4)      en = inn && v86 && !lng;
            else if (k < 6) en = inn || lng;
            else if (k < 9) en = 1'b1;
            else            en = herr;
            if (en) begin
                exp_addr[exp_n] = (base - 64'(exp_n + 1) * sz) & mask;
                exp_data[exp_n] = item_value(k) & dmask;
                exp_size[exp_n] = lng ? 2'd2 : (g32 ? 2'd1 : 2'd0);
                exp_kind[exp_n] = k;
                exp_n++;
            end
        end
        exp_sp = (sp & ~mask) | ((base - 64'(exp_n) * sz) & mask);
    endtask

    task automatic run_frame(input int combo, input logic [63:0] sp, input bit poke);
        bit g32, s32, inn, v86, lng, herr;
        bit acc_prev, stalled, finished, rdy;
        logic [63:0] pa, pd;
        int k;
        string tag;
        g32 = combo[0]; s32 = combo[1]; inn = combo[2];
        v86 = combo[3]; lng = combo[4]; herr = combo[5];
        build_expected(g32, s32, inn, v86, lng, herr, sp);
        @(negedge clk);
        in_gate32 = g32; in_stack32 = s32; in_inner = inn;
        in_v86 = v86; in_long64 = lng; in_has_err = herr;
        start_sp = sp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0; acc_prev = 0; stalled = 0; finished = 0; pa = '0; pd = '0;
        for (int c = 0; c < 200; c++) begin
            if (poke && c == 0) begin
                start = 1'b1; in_long64 = ~lng; in_inner = ~inn; in_gate32 = ~g32;
                start_sp = 64'h5555_0000_0000_0100;
            end
            if (poke && c == 1) begin
                start = 1'b0; in_long64 = lng; in_inner = inn; in_gate32 = g32;
                start_sp = sp;
            end
            if (stalled) begin
                check(wr_valid === 1'b1 && wr_addr === pa && wr_data === pd,
                      "R9", "stalled write held", wr_addr, pa);
            end
            if (acc_prev && k == exp_n) begin
                check(done === 1'b1, "R10", "done after last write", 64'(done), 64'd1);
                check(wr_valid === 1'b0, "R10", "no write with done", 64'(wr_valid), 64'd0);
                tag = lng ? "R8" : (!s32 ? "R7" : "R10");
                check(new_sp === exp_sp, tag, "final pointer", new_sp, exp_sp);
                finished = 1;
                break;
            end
            if (done) begin
                check(1'b0, "R10", "done too early", 64'(k), 64'(exp_n));
                break;
            end
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            rdy = lf[0] | lf[2];
            wr_ready = rdy;
            acc_prev = 0; stalled = 0;
            if (wr_valid) begin
                if (k >= exp_n) begin
                    check(1'b0, "R10", "extra write", 64'(k), 64'(exp_n));
                end else if (rdy) begin
                    if (poke)                      tag = "R11";
                    else if (lng)                  tag = "R8";
                    else if (!s32)                 tag = "R7";
                    else if (exp_kind[k] == 9)     tag = "R4";
                    else if (exp_kind[k] < 4)      tag = "R5";
                    else if (!inn)                 tag = "R6";
                    else                           tag = g32 ? "R2" : "R3";
                    check(wr_addr === exp_addr[k], tag, "address", wr_addr, exp_addr[k]);
                    check(wr_data === exp_data[k], tag, "data", wr_data, exp_data[k]);
                    check(wr_size === exp_size[k], tag, "size", 64'(wr_size), 64'(exp_size[k]));
                    k++;
                    acc_prev = 1;
                end else begin
                    stalled = 1; pa = wr_addr; pd = wr_data;
                end
            end
            @(negedge clk);
        end
        if (!finished) begin
            check(1'b0, "R10", "frame did not finish", 64'(k), 64'(exp_n));
        end
        start = 1'b0;
        wr_ready = 1'b0;
        @(negedge clk);
        check(done === 1'b0 && new_sp === exp_sp, "R10", "pointer held after done", new_sp, exp_sp);
    endtask

    initial begin
        logic [63:0] sps [3];
        sps[0] = 64'h0000_0001_8000_1237;
        sps[1] = 64'h0000_0000_FFFF_0006;
        sps[2] = 64'h0000_0000_0000_0004;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(busy === 1'b0 && wr_valid === 1'b0, "R1", "idle after reset", 64'({busy, wr_valid}), 64'd0);
        check(done === 1'b0, "R1", "done after reset", 64'(done), 64'd0);
        check(new_sp === 64'd0, "R1", "pointer after reset", new_sp, 64'd0);
        for (int s = 0; s < 3; s++) begin
            for (int combo = 0; combo < 64; combo++) begin
                run_frame(combo, sps[s], ((combo + s) % 5) == 2);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule